// File: doc/BRIEF.md
# Register File with Shadow Custom Registers

This block is the register storage for a single-issue five-stage RISC core that carries custom-instruction extensions. It combines a sixteen-entry general register file, with two read ports and one write port, and a two-entry custom register bank. Every write-back carries a small selector field. That field can copy the same result into one custom register in the same cycle as the general write, so filling the custom bank costs no extra instruction.

The custom bank is also part of the base register space. Two otherwise unused addresses name the custom registers, so a base instruction can read or write them like any other register. A compiler can therefore park a variable there instead of spilling it to memory. A custom instruction reads its extra operands from a dedicated output that always shows both custom registers, next to the two general read ports.

Top module: `shadow_regfile`

## Requirements
- R1: A write-back with `wb_en` high and `wb_addr` in 1..15 stores `wb_data`, and from the next cycle either base read port addressing that register returns it.
- R2: Address 0 always reads as zero on both base read ports, and a write-back to address 0 has no effect.
- R3: With `wb_en` high, a `wb_cust_sel` value of 2'b01 copies `wb_data` into custom register 0 and 2'b10 copies it into custom register 1. This happens in the same cycle as the write at `wb_addr`.
- R4: A `wb_cust_sel` value of 2'b00 (skip) or 2'b11 (reserved) leaves both custom registers unchanged.
- R5: Address 30 names custom register 0 and address 31 names custom register 1, for both base reads and write-back writes.
- R6: A read that targets the register being written in the same cycle returns the new `wb_data` (write-first). This holds for the base read ports and for the custom read output.
- R7: Addresses 16 to 29 read as zero, and writes to them are discarded.
- R8: `cust_rd` always shows custom register 0 on bits [31:0] and custom register 1 on bits [63:32].
- R9: While `rst_n` is low at a rising clock edge, every general and custom register clears to zero, and this overrides any write in that cycle.
- R10: With `wb_en` low, `wb_cust_sel` is ignored and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_addr_a | input | 5 | Base read port A address |
| rd_data_a | output | 32 | Base read port A data (combinational, with write-first bypass) |
| rd_addr_b | input | 5 | Base read port B address |
| rd_data_b | output | 32 | Base read port B data (combinational, with write-first bypass) |
| wb_en | input | 1 | Write-back enable for this cycle |
| wb_addr | input | 5 | Write-back destination address |
| wb_data | input | 32 | Write-back result |
| wb_cust_sel | input | 2 | Custom copy selector: 00 skip, 01 custom 0, 10 custom 1, 11 reserved |
| cust_rd | output | 64 | Both custom registers side by side, register 0 in the low half |

## Verification
A vector table drives write-backs that combine a general destination with each selector code. From these the bench can tell a correct custom copy from a copy into the wrong custom register and from a copy into none. Reads of the register being written in the same cycle separate write-first behaviour from read-old-value behaviour. Writes to address 0, to the 16–29 gap and to 30/31, and writes with the enable low, separate real storage from silent discards. A directed reset applied while a write is pending shows whether reset overrides the write.

// File: rtl/srf_pkg.sv
// Package: shared constants for the shadow register file.
// Assumes the default geometry: 5-bit addresses and a 2-bit custom selector.
package srf_pkg;

    // Custom-copy selector codes carried with each write-back.
    typedef enum logic [1:0] {
        CSEL_SKIP  = 2'b00,
        CSEL_CUST0 = 2'b01,
        CSEL_CUST1 = 2'b10,
        CSEL_RSVD  = 2'b11
    } csel_e;

    // Width needed to encode "none" plus one code per custom register.
    function automatic int sel_width(input int cust_depth);
        return $clog2(cust_depth + 1);
    endfunction

endpackage

// File: rtl/srf_wb_decode.sv
// Module: srf_wb_decode
// Turns one write-back (address, enable, custom selector) into one write
// enable per general register and per custom register.
// Assumes: general registers sit at addresses 0..GEN_DEPTH-1 with entry 0
// hard-wired to zero, and custom registers sit at CUST_BASE.. upward.
// Selector code k (1..CUST_DEPTH) copies into custom register k-1.
module srf_wb_decode #(
    parameter int ADDR_W     = 5,
    parameter int GEN_DEPTH  = 16,
    parameter int CUST_DEPTH = 2,
    parameter int CUST_BASE  = 30,
    parameter int SEL_W      = 2
) (
    input  logic                  wb_en,
    input  logic [ADDR_W-1:0]     wb_addr,
    input  logic [SEL_W-1:0]      wb_cust_sel,
    output logic [GEN_DEPTH-1:0]  gen_we,
    output logic [CUST_DEPTH-1:0] cust_we
);

    // One enable per general entry; entry 0 never writes.
    for (genvar gi = 0; gi < GEN_DEPTH; gi++) begin : g_gen_we
        if (gi == 0) begin : g_zero
            assign gen_we[gi] = 1'b0;
        end else begin : g_live
            localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(gi);
            assign gen_we[gi] = wb_en && (wb_addr == MY_ADDR);
        end
    end

    // One enable per custom entry: direct address or selector copy.
    for (genvar ci = 0; ci < CUST_DEPTH; ci++) begin : g_cust_we
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CUST_BASE + ci);
        localparam logic [SEL_W-1:0]  MY_SEL  = SEL_W'(ci + 1);
        assign cust_we[ci] = wb_en &&
                             ((wb_addr == MY_ADDR) || (wb_cust_sel == MY_SEL));
    end

endmodule

// File: rtl/srf_reg_bank.sv
// Module: srf_reg_bank
// A bank of DEPTH registers sharing one write data bus, each with its own
// write enable. Presents a "view" per entry that already reflects a write
// happening this cycle (write-first bypass).
// Assumes: synchronous active-low reset clears every entry; reset wins.
module srf_reg_bank #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [DEPTH-1:0]              we,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DEPTH-1:0][DATA_W-1:0]  view
);

    logic [DEPTH-1:0][DATA_W-1:0] q;

    for (genvar ei = 0; ei < DEPTH; ei++) begin : g_entry
        // Store one entry: clear on reset, load on its enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[ei] <= '0;
            end else if (we[ei]) begin
                q[ei] <= wdata;
            end
        end

        // Forward a same-cycle write ahead of the stored value.
        assign view[ei] = we[ei] ? wdata : q[ei];
    end

endmodule

// File: rtl/srf_read_mux.sv
// Module: srf_read_mux
// One base read port: selects a general or custom entry view by address,
// and returns zero for addresses that map to neither bank.
// Assumes: GEN_DEPTH <= CUST_BASE so the two ranges do not overlap.
module srf_read_mux #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 5,
    parameter int GEN_DEPTH  = 16,
    parameter int CUST_DEPTH = 2,
    parameter int CUST_BASE  = 30
) (
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [GEN_DEPTH-1:0][DATA_W-1:0]  gen_view,
    input  logic [CUST_DEPTH-1:0][DATA_W-1:0] cust_view,
    output logic [DATA_W-1:0]                 data
);

    // Address match over both banks; unmatched addresses give zero.
    always_comb begin
        data = '0;
        for (int gi = 0; gi < GEN_DEPTH; gi++) begin
            if (addr == ADDR_W'(gi)) begin
                data = gen_view[gi];
            end
        end
        for (int ci = 0; ci < CUST_DEPTH; ci++) begin
            if (addr == ADDR_W'(CUST_BASE + ci)) begin
                data = cust_view[ci];
            end
        end
    end

endmodule

// File: rtl/shadow_regfile.sv
// Module: shadow_regfile (top)
// General register file (two read ports, one write port) plus a bank of
// custom registers. Each write-back can also copy its result into one
// custom register, chosen by wb_cust_sel, in the same cycle. Base reads
// reach the custom registers through addresses CUST_BASE and up.
// Assumes: write-back inputs are valid on the clock edge they are meant
// for; reads are combinational and see same-cycle writes.
module shadow_regfile #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 5,
    parameter int GEN_DEPTH  = 16,
    parameter int CUST_DEPTH = 2,
    parameter int CUST_BASE  = 30,
    parameter int SEL_W      = srf_pkg::sel_width(CUST_DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            rd_addr_a,
    output logic [DATA_W-1:0]            rd_data_a,
    input  logic [ADDR_W-1:0]            rd_addr_b,
    output logic [DATA_W-1:0]            rd_data_b,
    input  logic                         wb_en,
    input  logic [ADDR_W-1:0]            wb_addr,
    input  logic [DATA_W-1:0]            wb_data,
    input  logic [SEL_W-1:0]             wb_cust_sel,
    output logic [CUST_DEPTH*DATA_W-1:0] cust_rd
);

    localparam int N_RD = 2;

    logic [GEN_DEPTH-1:0]              gen_we;
    logic [CUST_DEPTH-1:0]             cust_we;
    logic [GEN_DEPTH-1:0][DATA_W-1:0]  gen_view;
    logic [CUST_DEPTH-1:0][DATA_W-1:0] cust_view;
    logic [N_RD-1:0][ADDR_W-1:0]       rd_addr_v;
    logic [N_RD-1:0][DATA_W-1:0]       rd_data_v;

    srf_wb_decode #(
        .ADDR_W    (ADDR_W),
        .GEN_DEPTH (GEN_DEPTH),
        .CUST_DEPTH(CUST_DEPTH),
        .CUST_BASE (CUST_BASE),
        .SEL_W     (SEL_W)
    ) u_decode (
        .wb_en      (wb_en),
        .wb_addr    (wb_addr),
        .wb_cust_sel(wb_cust_sel),
        .gen_we     (gen_we),
        .cust_we    (cust_we)
    );

    srf_reg_bank #(
        .DATA_W(DATA_W),
        .DEPTH (GEN_DEPTH)
    ) u_gen_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (gen_we),
        .wdata(wb_data),
        .view (gen_view)
    );

    srf_reg_bank #(
        .DATA_W(DATA_W),
        .DEPTH (CUST_DEPTH)
    ) u_cust_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (cust_we),
        .wdata(wb_data),
        .view (cust_view)
    );

    assign rd_addr_v[0] = rd_addr_a;
    assign rd_addr_v[1] = rd_addr_b;

    for (genvar pi = 0; pi < N_RD; pi++) begin : g_rd_port
        srf_read_mux #(
            .DATA_W    (DATA_W),
            .ADDR_W    (ADDR_W),
            .GEN_DEPTH (GEN_DEPTH),
            .CUST_DEPTH(CUST_DEPTH),
            .CUST_BASE (CUST_BASE)
        ) u_mux (
            .addr     (rd_addr_v[pi]),
            .gen_view (gen_view),
            .cust_view(cust_view),
            .data     (rd_data_v[pi])
        );
    end

    assign rd_data_a = rd_data_v[0];
    assign rd_data_b = rd_data_v[1];

    // Custom-instruction operand output: all custom views side by side.
    for (genvar ci = 0; ci < CUST_DEPTH; ci++) begin : g_cust_out
        assign cust_rd[ci*DATA_W +: DATA_W] = cust_view[ci];
    end

endmodule

// File: rtl/srf_checker.sv
// Module: srf_checker
// Temporal checks on the shadow register file, bound to every instance of
// shadow_regfile. Observes ports only.
// Assumes: parameters match the bound instance (passed through the bind).
module srf_checker #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 5,
    parameter int GEN_DEPTH  = 16,
    parameter int CUST_DEPTH = 2,
    parameter int CUST_BASE  = 30,
    parameter int SEL_W      = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [ADDR_W-1:0]            rd_addr_a,
    input logic [DATA_W-1:0]            rd_data_a,
    input logic [ADDR_W-1:0]            rd_addr_b,
    input logic [DATA_W-1:0]            rd_data_b,
    input logic                         wb_en,
    input logic [ADDR_W-1:0]            wb_addr,
    input logic [DATA_W-1:0]            wb_data,
    input logic [SEL_W-1:0]             wb_cust_sel,
    input logic [CUST_DEPTH*DATA_W-1:0] cust_rd
);

    localparam logic [ADDR_W-1:0] GEN_TOP  = ADDR_W'(GEN_DEPTH);
    localparam logic [ADDR_W-1:0] CBASE    = ADDR_W'(CUST_BASE);
    localparam logic [SEL_W-1:0]  SEL_C0   = SEL_W'(1);
    localparam logic [SEL_W-1:0]  SEL_LAST = SEL_W'(CUST_DEPTH);

    // Previous edge was out of reset; starts low before the first edge.
    logic prev_run = 1'b0;
    always_ff @(posedge clk) prev_run <= rst_n;

    logic gen_write_now;
    logic cust_write_now;
    assign gen_write_now  = wb_en && (wb_addr != '0) && (wb_addr < GEN_TOP);
    assign cust_write_now = wb_en && (((wb_cust_sel != '0) && (wb_cust_sel <= SEL_LAST))
                                      || (wb_addr >= CBASE));

    AST_GEN_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_run && $past(gen_write_now) && (rd_addr_a == $past(wb_addr))
         && !(wb_en && (wb_addr == rd_addr_a)))
        |-> (rd_data_a == $past(wb_data))); // R1

    AST_ZERO_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a == '0) |-> (rd_data_a == '0)); // R2

    AST_CUST0_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_run && $past(wb_en && (wb_cust_sel == SEL_C0)) && !cust_write_now)
        |-> (cust_rd[DATA_W-1:0] == $past(wb_data))); // R3

    AST_RESERVED_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_run && $past(wb_en && (wb_cust_sel > SEL_LAST) && (wb_addr < GEN_TOP))
         && !cust_write_now)
        |-> (cust_rd == $past(cust_rd))); // R4

    AST_BYPASS_GENERAL: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_write_now && (rd_addr_b == wb_addr)) |-> (rd_data_b == wb_data)); // R6

    AST_GAP_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_addr_b >= GEN_TOP) && (rd_addr_b < CBASE)) |-> (rd_data_b == '0)); // R7

    AST_IDLE_KEEPS_CUSTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_run && $past(!wb_en) && !wb_en) |-> $stable(cust_rd)); // R10

endmodule

bind shadow_regfile srf_checker #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .GEN_DEPTH (GEN_DEPTH),
    .CUST_DEPTH(CUST_DEPTH),
    .CUST_BASE (CUST_BASE),
    .SEL_W     (SEL_W)
) u_srf_checker (.*);

// File: tb/shadow_regfile_test.sv
// Bench for shadow_regfile: a vector table walked by one loop, then
// directed reset tests. Inputs change on the falling edge; outputs are
// sampled 2 ns later, before the next rising edge.
module shadow_regfile_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_addr_a = '0;
    logic [31:0] rd_data_a;
    logic [4:0]  rd_addr_b = '0;
    logic [31:0] rd_data_b;
    logic        wb_en = 1'b0;
    logic [4:0]  wb_addr = '0;
    logic [31:0] wb_data = '0;
    logic [1:0]  wb_cust_sel = '0;
    logic [63:0] cust_rd;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    shadow_regfile uut (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
        .wb_cust_sel(wb_cust_sel), .cust_rd(cust_rd)
    );

    typedef struct packed {
        logic        en;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic [1:0]  sel;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic [31:0] ea;
        logic [31:0] eb;
        logic [31:0] e0;
        logic [31:0] e1;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 13;
    // Expected outputs seen in the same cycle the vector is driven.
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'd3,  32'h0000_00A1, 2'b00, 5'd3,  5'd0,  32'h0000_00A1, 32'h0,         32'h0,         32'h0,         8'd6},
        '{1'b1, 5'd5,  32'h0000_00B2, 2'b01, 5'd3,  5'd5,  32'h0000_00A1, 32'h0000_00B2, 32'h0000_00B2, 32'h0,         8'd3},
        '{1'b1, 5'd7,  32'h0000_00C3, 2'b10, 5'd5,  5'd7,  32'h0000_00B2, 32'h0000_00C3, 32'h0000_00B2, 32'h0000_00C3, 8'd3},
        '{1'b1, 5'd9,  32'h0000_00D4, 2'b11, 5'd30, 5'd31, 32'h0000_00B2, 32'h0000_00C3, 32'h0000_00B2, 32'h0000_00C3, 8'd4},
        '{1'b1, 5'd0,  32'h0000_00E5, 2'b00, 5'd0,  5'd9,  32'h0,         32'h0000_00D4, 32'h0000_00B2, 32'h0000_00C3, 8'd2},
        '{1'b0, 5'd11, 32'h0000_00F6, 2'b01, 5'd11, 5'd0,  32'h0,         32'h0,         32'h0000_00B2, 32'h0000_00C3, 8'd10},
        '{1'b1, 5'd30, 32'h0000_1111, 2'b00, 5'd30, 5'd11, 32'h0000_1111, 32'h0,         32'h0000_1111, 32'h0000_00C3, 8'd5},
        '{1'b1, 5'd20, 32'h0000_2222, 2'b00, 5'd20, 5'd30, 32'h0,         32'h0000_1111, 32'h0000_1111, 32'h0000_00C3, 8'd7},
        '{1'b1, 5'd31, 32'h0000_3333, 2'b01, 5'd31, 5'd30, 32'h0000_3333, 32'h0000_3333, 32'h0000_3333, 32'h0000_3333, 8'd6},
        '{1'b0, 5'd0,  32'h0,         2'b00, 5'd20, 5'd31, 32'h0,         32'h0000_3333, 32'h0000_3333, 32'h0000_3333, 8'd7},
        '{1'b1, 5'd15, 32'h0000_4444, 2'b10, 5'd15, 5'd7,  32'h0000_4444, 32'h0000_00C3, 32'h0000_3333, 32'h0000_4444, 8'd8},
        '{1'b0, 5'd0,  32'h0,         2'b00, 5'd15, 5'd3,  32'h0000_4444, 32'h0000_00A1, 32'h0000_3333, 32'h0000_4444, 8'd1},
        '{1'b0, 5'd0,  32'h0,         2'b00, 5'd9,  5'd0,  32'h0000_00D4, 32'h0,         32'h0000_3333, 32'h0000_4444, 8'd2}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic en, input logic [4:0] wa, input logic [31:0] wd,
                         input logic [1:0] sel, input logic [4:0] ra, input logic [4:0] rb);
        @(negedge clk);
        wb_en = en; wb_addr = wa; wb_data = wd; wb_cust_sel = sel;
        rd_addr_a = ra; rd_addr_b = rb;
        #2;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (25000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        // R9: reset state after power-up reset.
        repeat (3) @(posedge clk);
        drive(1'b0, 5'd0, 32'h0, 2'b00, 5'd3, 5'd31);
        rst_n = 1'b1;
        #0;
        check("R9", "reset rd_a", rd_data_a, 32'h0);
        check("R9", "reset rd_b", rd_data_b, 32'h0);
        check("R9", "reset cust0", cust_rd[31:0], 32'h0);
        check("R9", "reset cust1", cust_rd[63:32], 32'h0);

        // Vector table: R1..R8, R10 by tag in each row.
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            drive(VECS[i].en, VECS[i].wa, VECS[i].wd, VECS[i].sel, VECS[i].ra, VECS[i].rb);
            check(tag, $sformatf("vec%0d rd_a", i), rd_data_a, VECS[i].ea);
            check(tag, $sformatf("vec%0d rd_b", i), rd_data_b, VECS[i].eb);
            check(tag, $sformatf("vec%0d cust0", i), cust_rd[31:0], VECS[i].e0);
            check(tag, $sformatf("vec%0d cust1", i), cust_rd[63:32], VECS[i].e1);
        end

        // R8: halves of cust_rd map to custom 0 and custom 1 separately.
        drive(1'b1, 5'd0, 32'h0000_5A5A, 2'b01, 5'd0, 5'd0);
        drive(1'b0, 5'd0, 32'h0, 2'b00, 5'd30, 5'd31);
        check("R8", "cust0 low half", cust_rd[31:0], 32'h0000_5A5A);
        check("R8", "cust1 high half", cust_rd[63:32], 32'h0000_4444);
        check("R5", "addr31 after copy to 0", rd_data_b, 32'h0000_4444);

        // R9: reset overrides a write-back pending in the same cycle.
        @(negedge clk);
        rst_n = 1'b0;
        wb_en = 1'b1; wb_addr = 5'd3; wb_data = 32'hFFFF_FFFF; wb_cust_sel = 2'b01;
        drive(1'b0, 5'd0, 32'h0, 2'b00, 5'd3, 5'd15);
        rst_n = 1'b1;
        #0;
        check("R9", "reset beats write rd_a", rd_data_a, 32'h0);
        check("R9", "reset clears rd_b", rd_data_b, 32'h0);
        check("R9", "reset beats copy cust0", cust_rd[31:0], 32'h0);
        check("R9", "reset clears cust1", cust_rd[63:32], 32'h0);

        finished = 1'b1;
        summary();
    end

endmodule